// File: doc/BRIEF.md
# Receive FIFO Hysteresis Flow-Control Controller

This block drives an active-low ready-to-send handshake output for a serial receiver. It watches the occupancy count of the receive FIFO. When the count climbs to an upper trip level, it tells the remote sender to stop by driving the output high. It drives the output low again only once the count has drained to a lower trip level. The gap between the two levels is a hysteresis band, so the handshake line does not chatter while the FIFO hovers near one level. The FIFO itself keeps taking bytes after the line goes high, right up to full. This block only advises the sender and never blocks writes. The FIFO, the serializer and the register bus are outside the block.

The trip levels come from one of two sources. The first is a compact 4-bit legacy trigger code that maps through a fixed arithmetic table. The second is a pair of byte-granular upper and lower thresholds. The byte-granular pair is used as soon as any of four extended level registers holds a non-zero value. The block also raises a registered receive-level interrupt request when the count reaches the receive trigger level. That request is independent of the handshake levels and of the flow-control enable.

Top module: `rx_rts_hysteresis`

## Requirements
- R1: While reset is active, and on the first cycles after it, rts_n is 0 (ready to receive) and rx_irq is 0.
- R2: When flow_en is 0, rts_n is 0 one clock after the inputs are applied, whatever the FIFO count.
- R3: With flow_en at 1, a count greater than or equal to the upper trip level makes rts_n 1 one clock later.
- R4: With flow_en at 1, a count below the upper trip level and at or below the lower trip level makes rts_n 0 one clock later.
- R5: With flow_en at 1, a count strictly between the lower and upper trip levels leaves rts_n unchanged (hysteresis).
- R6: The extended source is selected when any one of lvl_tx, lvl_rx, thr_hi, thr_lo is non-zero. When all four are zero, the legacy code is used. The extended source is selected even when only lvl_tx or only lvl_rx is non-zero, in which case the trip levels are thr_hi = 0 and thr_lo = 0.
- R7: Legacy code k (0..15) gives an upper trip level of (k+1)·DEPTH/16 and a lower trip level of k·DEPTH/16.
- R8: In extended mode, thr_hi and thr_lo are used directly as byte counts. Any value from 1 to DEPTH is accepted in steps of 1. Software keeps thr_hi above thr_lo, and the block does not check this.
- R9: rx_irq is registered and equals 1 one clock after the count is at or above the receive trigger level, and 0 otherwise. In extended mode the receive trigger level is lvl_rx, with 0 treated as 1. In legacy mode it is the legacy upper trip level. flow_en has no effect on rx_irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flow_en | input | 1 | Enables the hysteresis handshake |
| lvl_tx | input | LVL_W | Extended transmit level register (only takes part in source selection) |
| lvl_rx | input | LVL_W | Extended receive trigger level |
| thr_hi | input | LVL_W | Extended upper trip level |
| thr_lo | input | LVL_W | Extended lower trip level |
| legacy_code | input | 4 | Legacy trigger code |
| fifo_count | input | LVL_W | Receive FIFO occupancy, 0..DEPTH |
| rts_n | output | 1 | Active-low handshake: 0 ready, 1 stop |
| rx_irq | output | 1 | Receive-level interrupt request |

LVL_W is $clog2(DEPTH+1).

## Verification
The hardest state to reach is the hold inside the hysteresis band. On the way up the band must keep rts_n at 0, and on the way down it must keep rts_n at 1. A single level test cannot tell these two cases apart. The bench therefore ramps the count from empty to full and back to empty for every legacy code and for every valid upper/lower pair of a 32-deep configuration. Between pairs it pulses the enable low, so each ramp starts from a known low state and crosses the band in both directions. A further set of cases places a non-zero value in only one extended register at a time. This shows that the source switch follows each register on its own.

// File: rtl/rts_hys_pkg.sv
package rts_hys_pkg;
  // Handshake line levels (active-low ready)
  typedef enum logic {
    RTS_READY = 1'b0,
    RTS_STOP  = 1'b1
  } rts_lvl_e;

  localparam int LEGACY_STEPS = 16;
endpackage

// File: rtl/rts_hys_rst_sync.sv
module rts_hys_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rts_hys_level_sel.sv
module rts_hys_level_sel #(
  parameter int DEPTH = 128,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [LVL_W-1:0] lvl_tx,
  input  logic [LVL_W-1:0] lvl_rx,
  input  logic [LVL_W-1:0] thr_hi,
  input  logic [LVL_W-1:0] thr_lo,
  input  logic [3:0]       legacy_code,
  output logic [LVL_W-1:0] trip_hi,
  output logic [LVL_W-1:0] trip_lo,
  output logic [LVL_W-1:0] trip_rx
);
  import rts_hys_pkg::*;

  localparam int STEP = DEPTH / LEGACY_STEPS;

  logic             ext_mode;
  logic [LVL_W-1:0] leg_hi;
  logic [LVL_W-1:0] leg_lo;
  logic [LVL_W-1:0] ext_rx;

  // R7: legacy table computed arithmetically
  always_comb begin
    leg_lo = LVL_W'(int'(legacy_code) * STEP);
    leg_hi = LVL_W'((int'(legacy_code) + 1) * STEP);
  end

  // R6: any non-zero extended register selects the extended source
  always_comb begin
    ext_mode = |{lvl_tx, lvl_rx, thr_hi, thr_lo};
    ext_rx   = (lvl_rx == '0) ? LVL_W'(1) : lvl_rx;
    if (ext_mode) begin
      trip_hi = thr_hi;
      trip_lo = thr_lo;
      trip_rx = ext_rx;
    end else begin
      trip_hi = leg_hi;
      trip_lo = leg_lo;
      trip_rx = leg_hi;
    end
  end
endmodule

// File: rtl/rts_hys_flow.sv
module rts_hys_flow #(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flow_en,
  input  logic [LVL_W-1:0] count,
  input  logic [LVL_W-1:0] trip_hi,
  input  logic [LVL_W-1:0] trip_lo,
  output logic             rts_n
);
  import rts_hys_pkg::*;

  rts_lvl_e rts_q, rts_d;
  logic     rts_upd;

  always_comb begin
    if (!flow_en)               rts_d = RTS_READY;
    else if (count >= trip_hi)  rts_d = RTS_STOP;
    else if (count <= trip_lo)  rts_d = RTS_READY;
    else                        rts_d = rts_q;
    rts_upd = (rts_d != rts_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rts_q <= RTS_READY;
    else if (rts_upd) rts_q <= rts_d;
  end

  assign rts_n = rts_q;

  p_off_when_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !flow_en |=> (rts_n == 1'b0));

  p_trip_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en && count >= trip_hi) |=> (rts_n == 1'b1));

  p_release_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en && count < trip_hi && count <= trip_lo) |=> (rts_n == 1'b0));

  p_hold_band_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en && count < trip_hi && count > trip_lo) |=> $stable(rts_n));
endmodule

// File: rtl/rts_hys_rxirq.sv
module rts_hys_rxirq #(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] count,
  input  logic [LVL_W-1:0] trip_rx,
  output logic             rx_irq
);
  logic irq_q, irq_d, irq_upd;

  always_comb begin
    irq_d   = (count >= trip_rx);
    irq_upd = (irq_d != irq_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (irq_upd) irq_q <= irq_d;
  end

  assign rx_irq = irq_q;

  p_irq_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (count >= trip_rx) |=> rx_irq);

  p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (count < trip_rx) |=> !rx_irq);
endmodule

// File: rtl/rx_rts_hysteresis.sv
module rx_rts_hysteresis #(
  parameter int DEPTH = 128,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flow_en,
  input  logic [LVL_W-1:0] lvl_tx,
  input  logic [LVL_W-1:0] lvl_rx,
  input  logic [LVL_W-1:0] thr_hi,
  input  logic [LVL_W-1:0] thr_lo,
  input  logic [3:0]       legacy_code,
  input  logic [LVL_W-1:0] fifo_count,
  output logic             rts_n,
  output logic             rx_irq
);
  logic             rst_sync_n;
  logic [LVL_W-1:0] trip_hi, trip_lo, trip_rx;

  rts_hys_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  rts_hys_level_sel #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_sel (
    .lvl_tx(lvl_tx), .lvl_rx(lvl_rx), .thr_hi(thr_hi), .thr_lo(thr_lo),
    .legacy_code(legacy_code),
    .trip_hi(trip_hi), .trip_lo(trip_lo), .trip_rx(trip_rx)
  );

  rts_hys_flow #(.LVL_W(LVL_W)) u_flow (
    .clk(clk), .rst_n(rst_sync_n), .flow_en(flow_en), .count(fifo_count),
    .trip_hi(trip_hi), .trip_lo(trip_lo), .rts_n(rts_n)
  );

  rts_hys_rxirq #(.LVL_W(LVL_W)) u_irq (
    .clk(clk), .rst_n(rst_sync_n), .count(fifo_count),
    .trip_rx(trip_rx), .rx_irq(rx_irq)
  );

  // R1: outputs quiet while held in reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_sync_n |-> (!rts_n && !rx_irq));
endmodule

// File: tb/rx_rts_hysteresis_test.sv
`timescale 1ns/1ps
module rx_rts_hysteresis_test;
  localparam int DEPTH = 32;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int STEP  = DEPTH / 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             flow_en;
  logic [LVL_W-1:0] lvl_tx, lvl_rx, thr_hi, thr_lo, fifo_count;
  logic [3:0]       legacy_code;
  logic             rts_n, rx_irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit exp_rts;
  bit exp_irq;

  always #2.5 clk = ~clk;

  rx_rts_hysteresis #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .flow_en(flow_en),
    .lvl_tx(lvl_tx), .lvl_rx(lvl_rx), .thr_hi(thr_hi), .thr_lo(thr_lo),
    .legacy_code(legacy_code), .fifo_count(fifo_count),
    .rts_n(rts_n), .rx_irq(rx_irq)
  );

  task automatic check(input string req, input bit act, input bit exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b (count %0d code %0d hi %0d lo %0d rx %0d tx %0d en %0b)",
               req, act, exp, fifo_count, legacy_code, thr_hi, thr_lo, lvl_rx, lvl_tx, flow_en);
    end
  endtask

  // Apply inputs at a falling edge, predict, sample at the next falling edge.
  task automatic step(input int cnt, input string req);
    bit ext;
    int hi, lo, rxt;
    fifo_count = LVL_W'(cnt);
    ext = (lvl_tx != 0) || (lvl_rx != 0) || (thr_hi != 0) || (thr_lo != 0); // R6
    if (ext) begin
      hi  = thr_hi;                                // R8
      lo  = thr_lo;
      rxt = (lvl_rx == 0) ? 1 : int'(lvl_rx);
    end else begin
      hi  = (int'(legacy_code) + 1) * STEP;        // R7
      lo  = int'(legacy_code) * STEP;
      rxt = hi;
    end
    if (!flow_en)      exp_rts = 1'b0;             // R2
    else if (cnt >= hi) exp_rts = 1'b1;            // R3
    else if (cnt <= lo) exp_rts = 1'b0;            // R4
    exp_irq = (cnt >= rxt);                        // R9
    @(negedge clk);
    check(req, rts_n, exp_rts);
    check("R9", rx_irq, exp_irq);
  endtask

  task automatic ramp(input string req);
    for (int c = 0; c <= DEPTH; c++) step(c, req);
    for (int c = DEPTH; c >= 0; c--) step(c, req);
  endtask

  task automatic clear_regs();
    lvl_tx = '0; lvl_rx = '0; thr_hi = '0; thr_lo = '0;
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flow_en = 1'b1; legacy_code = 4'd0; fifo_count = LVL_W'(DEPTH);
    clear_regs();
    repeat (3) @(negedge clk);
    // R1: reset state even with a full FIFO and flow control enabled
    check("R1", rts_n, 1'b0);
    check("R1", rx_irq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", rts_n, 1'b0);
    check("R1", rx_irq, 1'b0);
    repeat (3) @(negedge clk);
    flow_en = 1'b0;
    step(0, "R2");

    // R2: disabled holds ready at every count
    for (int c = 0; c <= DEPTH; c++) step(c, "R2");

    // R3/R4/R5/R7: legacy sweep over every code
    for (int k = 0; k < 16; k++) begin
      legacy_code = 4'(k);
      flow_en = 1'b0; step(0, "R2");
      flow_en = 1'b1; ramp("R7");
    end

    // R3/R4/R5/R8: every valid extended pair, byte granular
    for (int h = 2; h <= DEPTH; h++) begin
      for (int l = 1; l < h; l++) begin
        thr_hi = LVL_W'(h); thr_lo = LVL_W'(l); lvl_rx = LVL_W'(l);
        flow_en = 1'b0; step(0, "R2");
        flow_en = 1'b1; ramp("R5");
      end
    end

    // R6: each extended register alone switches the source
    legacy_code = 4'd15;
    for (int r = 0; r < 4; r++) begin
      clear_regs();
      flow_en = 1'b0; step(0, "R2");
      case (r)
        0: lvl_tx = LVL_W'(1);
        1: lvl_rx = LVL_W'(3);
        2: thr_hi = LVL_W'(DEPTH);
        default: thr_lo = LVL_W'(1);
      endcase
      flow_en = 1'b1;
      step(0, "R6");
      step(2, "R6");
      step(5, "R6");
    end

    // R9: interrupt independent of the enable
    clear_regs(); legacy_code = 4'd3; flow_en = 1'b0;
    step(2 * 4 + 1, "R2");
    step(2 * 4, "R2");
    step(7, "R2");
    flow_en = 1'b1;
    step(8, "R3");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule